// File: doc/BRIEF.md
# Buffered Synchronous Serial Port

This block is a byte-oriented serial port with an independent transmit path and receive path. Both paths are timed by an internal bit clock. A sample-rate divider makes this clock from the core clock, or from half of it, and divides that input by a programmable 8-bit amount plus one. The generated clock is driven out on a pin. Transmit data changes when this clock rises. Receive data and receive frame-sync are sampled when it falls.

A host places a byte in the transmit holding register. The port announces the frame with a one-period frame-sync pulse and then shifts the byte out MSB first. Incoming frames begin when an active-high frame-sync is seen while the receiver is idle. Each finished byte passes from the receive shifter into a buffer register and then into the data register the host reads. The ready flag rises when the byte reaches the data register. Because the buffer register sits between the shifter and the data register, a slow host can fall two bytes behind before any data is lost.

Tying the receive frame-sync pin to the receive data pin lets the port accept an asynchronous byte stream whose leading high bit marks the frame.

Top module: `bsp_port`

## Requirements
- R1: The bit clock period is (D+1) core cycles when the half-rate select is 0, and 2·(D+1) core cycles when it is 1. D is the 8-bit divider field, and a field value of 0 is treated as 1.
- R2: With the half-rate select at 1 and the divider field at 239, one bit period lasts 480 core cycles, which gives 312.5 kb/s from a 150 MHz core clock.
- R3: The transmit frame-sync and data outputs change only on the core edge where the bit clock output rises. The receive pins are sampled on the core edge where it falls.
- R4: When the holding register is full and the transmitter is idle or finishing bit 0, the next bit clock rise moves the byte into the shifter. The transmit frame-sync is then high for exactly that one bit period, and the following 8 periods carry the byte on the data output, bit 7 first. The data output is low in the frame-sync period and when idle.
- R5: The transmit ready output is high exactly when the holding register is empty. A write while it is full is ignored, and the held byte is sent unchanged.
- R6: An idle receiver that samples the receive frame-sync high starts a frame. The next 8 sampling edges capture the data pin with bit 7 first, and zero data delay applies.
- R7: A receive frame-sync that is high while a frame is in progress is ignored. A new frame can start only once the receiver is idle.
- R8: A finished byte passes through a buffer register into the data register. The receive ready output is high while the data register holds an unread byte, and a read pulse removes that byte. A read promotes a waiting buffered byte, and a read with no byte present changes nothing.
- R9: A byte that finishes while both the buffer and data registers are full is discarded and sets the overrun flag. The stored bytes are kept, and the flag stays set until the next read pulse.
- R10: After reset, transmit ready is 1, while receive ready, overrun, bit clock, transmit frame-sync and transmit data are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_half | input | 1 | Divider input select: 1 = core clock / 2, 0 = core clock |
| cfg_div | input | DIV_W | Divider field D (period factor D+1) |
| tx_wr | input | 1 | Write strobe for the transmit holding register |
| tx_data | input | WORD_W | Byte to transmit |
| tx_ready | output | 1 | Holding register empty |
| rx_rd | input | 1 | Read strobe for the receive data register |
| rx_data | output | WORD_W | Receive data register |
| rx_ready | output | 1 | Unread byte present in the data register |
| rx_overrun | output | 1 | Sticky overrun flag, cleared by a read |
| bclk_o | output | 1 | Generated bit clock |
| tx_fs_o | output | 1 | Transmit frame-sync, active high |
| tx_sd_o | output | 1 | Transmit serial data |
| rx_fs_i | input | 1 | Receive frame-sync, active high |
| rx_sd_i | input | 1 | Receive serial data |

## Verification
The bench builds the port with its default 8-bit word and 8-bit divider field. This puts the full divider range within reach, including the 480-cycle half-rate setting, the zero-field clamp, and odd and even divisions. Most frame traffic runs at short bit periods, so loopback, tied frame-sync/data streams, the buffering chain and overrun all fit in a short run. A separate monitor in the bench decodes the transmit pins on its own, so a bit-order error cannot hide behind the loopback.

// File: rtl/bsp_pkg.sv
package bsp_pkg;

  localparam int unsigned BSP_WORD_W = 8;
  localparam int unsigned BSP_DIV_W  = 8;

  // Single-cycle strobes marking bit clock transitions.
  typedef struct packed {
    logic rise;
    logic fall;
  } bit_edges_t;

endpackage

// File: rtl/bsp_clkgen.sv
module bsp_clkgen import bsp_pkg::*; #(
  parameter int DIV_W = BSP_DIV_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_half,
  input  logic [DIV_W-1:0] cfg_div,
  output bit_edges_t       edges,
  output logic             bclk
);

  logic             half_ph_q, half_ph_d;
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             bclk_q, bclk_d;
  logic [DIV_W-1:0] lim;
  logic [DIV_W:0]   lim_p1;
  logic [DIV_W-1:0] fall_at;
  logic             tick;
  logic             rise_s, fall_s;

  always_comb begin
    lim       = (cfg_div == '0) ? DIV_W'(1) : cfg_div;
    lim_p1    = {1'b0, lim} + 1'b1;
    fall_at   = lim_p1[DIV_W:1] - 1'b1;
    tick      = cfg_half ? half_ph_q : 1'b1;
    half_ph_d = ~half_ph_q;
    rise_s    = tick && (cnt_q >= lim);
    fall_s    = tick && (cnt_q == fall_at);
    cnt_d     = cnt_q;
    if (tick) begin
      cnt_d = rise_s ? '0 : cnt_q + 1'b1;
    end
    bclk_d = bclk_q;
    if (rise_s) begin
      bclk_d = 1'b1;
    end else if (fall_s) begin
      bclk_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_ph_q <= 1'b0;
      cnt_q     <= '0;
      bclk_q    <= 1'b0;
    end else begin
      half_ph_q <= half_ph_d;
      cnt_q     <= cnt_d;
      bclk_q    <= bclk_d;
    end
  end

  assign edges.rise = rise_s;
  assign edges.fall = fall_s;
  assign bclk       = bclk_q;

endmodule

// File: rtl/bsp_tx.sv
module bsp_tx #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rise,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic         ready,
  output logic         fs,
  output logic         sd
);

  localparam int CW   = $clog2(W + 2);
  localparam int LAST = W + 1;

  logic [W-1:0]  thr_q, thr_d;
  logic          thr_full_q, thr_full_d;
  logic [W-1:0]  sh_q, sh_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          fs_q, fs_d;
  logic          sd_q, sd_d;
  logic          slot_free, start, accept;

  always_comb begin
    slot_free  = (cnt_q == '0) || (cnt_q == CW'(LAST));
    start      = rise && thr_full_q && slot_free;
    accept     = wr && (!thr_full_q || start);
    thr_d      = accept ? wdata : thr_q;
    thr_full_d = accept ? 1'b1 : (start ? 1'b0 : thr_full_q);

    sh_d  = sh_q;
    cnt_d = cnt_q;
    fs_d  = fs_q;
    sd_d  = sd_q;
    if (rise) begin
      if (slot_free) begin
        sd_d = 1'b0;
        if (thr_full_q) begin
          sh_d  = thr_q;
          cnt_d = CW'(1);
          fs_d  = 1'b1;
        end else begin
          cnt_d = '0;
          fs_d  = 1'b0;
        end
      end else begin
        fs_d  = 1'b0;
        sd_d  = sh_q[W-1];
        sh_d  = {sh_q[W-2:0], 1'b0};
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_q      <= '0;
      thr_full_q <= 1'b0;
      sh_q       <= '0;
      cnt_q      <= '0;
      fs_q       <= 1'b0;
      sd_q       <= 1'b0;
    end else begin
      thr_q      <= thr_d;
      thr_full_q <= thr_full_d;
      sh_q       <= sh_d;
      cnt_q      <= cnt_d;
      fs_q       <= fs_d;
      sd_q       <= sd_d;
    end
  end

  assign ready = ~thr_full_q;
  assign fs    = fs_q;
  assign sd    = sd_q;

endmodule

// File: rtl/bsp_rx.sv
module bsp_rx #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         fall,
  input  logic         fs_i,
  input  logic         sd_i,
  output logic         done,
  output logic [W-1:0] word
);

  localparam int CW = $clog2(W + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [W-1:0]  sh_q, sh_d;
  logic          done_q, done_d;

  always_comb begin
    cnt_d  = cnt_q;
    sh_d   = sh_q;
    done_d = 1'b0;
    if (fall) begin
      if (cnt_q == '0) begin
        if (fs_i) begin
          cnt_d = CW'(1);
        end
      end else begin
        sh_d = {sh_q[W-2:0], sd_i};
        if (cnt_q == CW'(W)) begin
          cnt_d  = '0;
          done_d = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sh_q   <= '0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      sh_q   <= sh_d;
      done_q <= done_d;
    end
  end

  assign done = done_q;
  assign word = sh_q;

endmodule

// File: rtl/bsp_rxbuf.sv
module bsp_rxbuf #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_word,
  input  logic         rd,
  output logic [W-1:0] data,
  output logic         ready,
  output logic         ovr
);

  logic [W-1:0] rbr_q, rbr_d;
  logic         rbr_full_q, rbr_full_d;
  logic [W-1:0] drr_q, drr_d;
  logic         drr_full_q, drr_full_d;
  logic         ovr_q, ovr_d;
  logic         drr_free, move, rbr_avail;

  always_comb begin
    drr_free  = !drr_full_q || rd;
    move      = rbr_full_q && drr_free;
    rbr_avail = !rbr_full_q || move;

    rbr_d      = rbr_q;
    rbr_full_d = rbr_full_q;
    if (push && rbr_avail) begin
      rbr_d      = push_word;
      rbr_full_d = 1'b1;
    end else if (move) begin
      rbr_full_d = 1'b0;
    end

    drr_d      = drr_q;
    drr_full_d = drr_full_q;
    if (move) begin
      drr_d      = rbr_q;
      drr_full_d = 1'b1;
    end else if (rd) begin
      drr_full_d = 1'b0;
    end

    ovr_d = ovr_q;
    if (push && !rbr_avail) begin
      ovr_d = 1'b1;
    end else if (rd) begin
      ovr_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbr_q      <= '0;
      rbr_full_q <= 1'b0;
      drr_q      <= '0;
      drr_full_q <= 1'b0;
      ovr_q      <= 1'b0;
    end else begin
      rbr_q      <= rbr_d;
      rbr_full_q <= rbr_full_d;
      drr_q      <= drr_d;
      drr_full_q <= drr_full_d;
      ovr_q      <= ovr_d;
    end
  end

  assign data  = drr_q;
  assign ready = drr_full_q;
  assign ovr   = ovr_q;

endmodule

// File: rtl/bsp_port.sv
module bsp_port import bsp_pkg::*; #(
  parameter int WORD_W = BSP_WORD_W,
  parameter int DIV_W  = BSP_DIV_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_half,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic              tx_wr,
  input  logic [WORD_W-1:0] tx_data,
  output logic              tx_ready,
  input  logic              rx_rd,
  output logic [WORD_W-1:0] rx_data,
  output logic              rx_ready,
  output logic              rx_overrun,
  output logic              bclk_o,
  output logic              tx_fs_o,
  output logic              tx_sd_o,
  input  logic              rx_fs_i,
  input  logic              rx_sd_i
);

  // Reset: asserted asynchronously, released on the clock.
  logic rst_meta_q, rst_sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  bit_edges_t        edges;
  logic              rx_done;
  logic [WORD_W-1:0] rx_word;

  bsp_clkgen #(.DIV_W(DIV_W)) u_clkgen (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .cfg_half (cfg_half),
    .cfg_div  (cfg_div),
    .edges    (edges),
    .bclk     (bclk_o)
  );

  bsp_tx #(.W(WORD_W)) u_tx (
    .clk   (clk),
    .rst_n (rst_sync_q),
    .rise  (edges.rise),
    .wr    (tx_wr),
    .wdata (tx_data),
    .ready (tx_ready),
    .fs    (tx_fs_o),
    .sd    (tx_sd_o)
  );

  bsp_rx #(.W(WORD_W)) u_rx (
    .clk   (clk),
    .rst_n (rst_sync_q),
    .fall  (edges.fall),
    .fs_i  (rx_fs_i),
    .sd_i  (rx_sd_i),
    .done  (rx_done),
    .word  (rx_word)
  );

  bsp_rxbuf #(.W(WORD_W)) u_rxbuf (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .push      (rx_done),
    .push_word (rx_word),
    .rd        (rx_rd),
    .data      (rx_data),
    .ready     (rx_ready),
    .ovr       (rx_overrun)
  );

endmodule

// File: rtl/bsp_port_chk.sv
module bsp_port_chk #(
  parameter int WORD_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tx_ready,
  input logic              tx_fs_o,
  input logic              tx_sd_o,
  input logic              bclk_o,
  input logic              rx_rd,
  input logic              rx_ready,
  input logic [WORD_W-1:0] rx_data,
  input logic              rx_overrun
);

  AST_TX_SD_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_sd_o != $past(tx_sd_o)) |-> $rose(bclk_o)); // R3

  AST_TX_FS_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_fs_o) |-> $rose(bclk_o)); // R4

  AST_TX_FS_ONE_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(tx_fs_o) && $rose(bclk_o)) |-> !tx_fs_o); // R4

  AST_TX_SD_LOW_IN_FS: assert property (@(posedge clk) disable iff (!rst_n)
    tx_fs_o |-> !tx_sd_o); // R4

  AST_TX_READY_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_ready) |-> $rose(bclk_o)); // R5

  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ready && !rx_rd) |=> (rx_ready && $stable(rx_data))); // R8

  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_overrun && !rx_rd) |=> rx_overrun); // R9

  AST_OVR_WITH_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    rx_overrun |-> rx_ready); // R9

endmodule

bind bsp_port bsp_port_chk #(.WORD_W(WORD_W)) u_chk (.*);

// File: tb/tb_bsp_port.sv
module tb_bsp_port;

  logic       clk;
  logic       rst_n;
  logic       cfg_half;
  logic [7:0] cfg_div;
  logic       tx_wr;
  logic [7:0] tx_data;
  logic       tx_ready;
  logic       rx_rd;
  logic [7:0] rx_data;
  logic       rx_ready;
  logic       rx_overrun;
  logic       bclk_o;
  logic       tx_fs_o;
  logic       tx_sd_o;
  logic       rx_fs_i;
  logic       rx_sd_i;
  logic       loop_en;
  logic       bfs;
  logic       bsd;

  int nvec;
  int nerr;

  assign rx_fs_i = loop_en ? tx_fs_o : bfs;
  assign rx_sd_i = loop_en ? tx_sd_o : bsd;

  bsp_port dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_half   (cfg_half),
    .cfg_div    (cfg_div),
    .tx_wr      (tx_wr),
    .tx_data    (tx_data),
    .tx_ready   (tx_ready),
    .rx_rd      (rx_rd),
    .rx_data    (rx_data),
    .rx_ready   (rx_ready),
    .rx_overrun (rx_overrun),
    .bclk_o     (bclk_o),
    .tx_fs_o    (tx_fs_o),
    .tx_sd_o    (tx_sd_o),
    .rx_fs_i    (rx_fs_i),
    .rx_sd_i    (rx_sd_i)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Independent decoder of the transmit pins, sampling at bit clock falls.
  logic [7:0] mon_q [0:15];
  int         m_frames;
  int         m_cnt;
  logic [7:0] m_word;
  logic       m_pb;

  always @(negedge clk) begin
    if (!rst_n) begin
      m_frames = 0;
      m_cnt    = 0;
      m_word   = 8'h00;
      m_pb     = 1'b0;
    end else begin
      if (m_pb && !bclk_o) begin
        if (m_cnt == 0) begin
          if (tx_fs_o) m_cnt = 1;
        end else begin
          m_word = {m_word[6:0], tx_sd_o};
          if (m_cnt == 8) begin
            mon_q[m_frames % 16] = m_word;
            m_frames = m_frames + 1;
            m_cnt = 0;
          end else begin
            m_cnt = m_cnt + 1;
          end
        end
      end
      m_pb = bclk_o;
    end
  end

  task automatic summary_and_end();
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr = nerr + 1;
    $display("FAIL watchdog: run did not complete, actual=timeout expected=done");
    summary_and_end();
  end

  task automatic chk(string req, string what, int act, int exp);
    nvec = nvec + 1;
    if (act != exp) begin
      nerr = nerr + 1;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wait_rise();
    logic pb;
    pb = bclk_o;
    forever begin
      @(negedge clk);
      if (!pb && bclk_o) break;
      pb = bclk_o;
    end
  endtask

  task automatic wait_rx(int limit);
    for (int i = 0; i < limit; i++) begin
      if (rx_ready) break;
      @(negedge clk);
    end
  endtask

  task automatic wr_raw(logic [7:0] w);
    tx_wr   = 1'b1;
    tx_data = w;
    @(negedge clk);
    tx_wr   = 1'b0;
  endtask

  task automatic wr_word(logic [7:0] w);
    for (int i = 0; i < 2000; i++) begin
      if (tx_ready) break;
      @(negedge clk);
    end
    wr_raw(w);
  endtask

  task automatic rd_pulse();
    rx_rd = 1'b1;
    @(negedge clk);
    rx_rd = 1'b0;
  endtask

  task automatic pop(string req, logic [7:0] exp);
    chk(req, "rx_ready before read", int'(rx_ready), 1);
    chk(req, "rx_data", int'(rx_data), int'(exp));
    rd_pulse();
  endtask

  task automatic send_frame(logic [7:0] w, bit tied);
    wait_rise();
    bfs = 1'b1;
    bsd = tied ? 1'b1 : 1'b0;
    for (int i = 7; i >= 0; i--) begin
      wait_rise();
      bfs = tied ? w[i] : 1'b0;
      bsd = w[i];
    end
    wait_rise();
    bfs = 1'b0;
    bsd = 1'b0;
  endtask

  // R10: reset state
  task automatic t_reset();
    chk("R10", "tx_ready", int'(tx_ready), 1);
    chk("R10", "rx_ready", int'(rx_ready), 0);
    chk("R10", "rx_overrun", int'(rx_overrun), 0);
    chk("R10", "bclk_o", int'(bclk_o), 0);
    chk("R10", "tx_fs_o", int'(tx_fs_o), 0);
    chk("R10", "tx_sd_o", int'(tx_sd_o), 0);
  endtask

  // R1 / R2: bit period measured between consecutive rises
  task automatic t_period(bit half, logic [7:0] div, int exp, string req);
    int n;
    logic pb;
    cfg_half = half;
    cfg_div  = div;
    wait_rise();
    wait_rise();
    n  = 0;
    pb = bclk_o;
    forever begin
      @(negedge clk);
      n = n + 1;
      if (!pb && bclk_o) break;
      pb = bclk_o;
      if (n > 5000) break;
    end
    chk(req, "bit period cycles", n, exp);
  endtask

  // R4 R3 R6: loopback of one byte, decoded by the monitor and the receiver
  task automatic t_loop(logic [7:0] w);
    int m0;
    loop_en = 1'b1;
    m0 = m_frames;
    wr_word(w);
    wait_rx(2000);
    chk("R4", "frames seen on pins", m_frames - m0, 1);
    chk("R4", "pin-decoded byte MSB first", int'(mon_q[m0 % 16]), int'(w));
    pop("R6", w);
    chk("R8", "rx_ready after read", int'(rx_ready), 0);
  endtask

  // R6 / R7: externally driven frames, optionally with frame-sync tied to data
  task automatic t_async(logic [7:0] w, bit tied, string req);
    loop_en = 1'b0;
    send_frame(w, tied);
    wait_rx(200);
    pop(req, w);
  endtask

  // R8: two bytes queued through the buffer register
  task automatic t_buffer();
    loop_en = 1'b0;
    send_frame(8'h3C, 1'b0);
    send_frame(8'hC6, 1'b0);
    repeat (4) @(negedge clk);
    chk("R8", "oldest byte in data reg", int'(rx_data), 8'h3C);
    chk("R8", "no overrun with two bytes", int'(rx_overrun), 0);
    rd_pulse();
    chk("R8", "promoted byte", int'(rx_data), 8'hC6);
    chk("R8", "ready after promotion", int'(rx_ready), 1);
    rd_pulse();
    chk("R8", "ready after draining", int'(rx_ready), 0);
    rd_pulse();
    chk("R8", "empty read keeps ready low", int'(rx_ready), 0);
    chk("R8", "empty read keeps data", int'(rx_data), 8'hC6);
  endtask

  // R9: third byte with both registers full
  task automatic t_overrun();
    loop_en = 1'b0;
    send_frame(8'h11, 1'b0);
    send_frame(8'h22, 1'b0);
    chk("R9", "no overrun before third byte", int'(rx_overrun), 0);
    send_frame(8'h33, 1'b0);
    repeat (4) @(negedge clk);
    chk("R9", "overrun set", int'(rx_overrun), 1);
    chk("R9", "data reg kept", int'(rx_data), 8'h11);
    repeat (20) @(negedge clk);
    chk("R9", "overrun sticky", int'(rx_overrun), 1);
    rd_pulse();
    chk("R9", "overrun cleared by read", int'(rx_overrun), 0);
    chk("R9", "buffered byte kept", int'(rx_data), 8'h22);
    rd_pulse();
    chk("R9", "discarded byte absent", int'(rx_ready), 0);
  endtask

  // R5: holding register full, extra write ignored
  task automatic t_txhold();
    int m0;
    loop_en = 1'b1;
    m0 = m_frames;
    wr_word(8'h96);
    for (int i = 0; i < 200; i++) begin
      if (tx_ready) break;
      @(negedge clk);
    end
    chk("R5", "ready once byte moved to shifter", int'(tx_ready), 1);
    wr_raw(8'h4B);
    chk("R5", "not ready while holding full", int'(tx_ready), 0);
    wr_raw(8'hE1);
    wait_rx(400);
    pop("R5", 8'h96);
    wait_rx(400);
    pop("R5", 8'h4B);
    repeat (150) @(negedge clk);
    chk("R5", "write while full ignored (frames)", m_frames - m0, 2);
    chk("R5", "second frame on pins", int'(mon_q[(m0 + 1) % 16]), 8'h4B);
    chk("R5", "no third byte received", int'(rx_ready), 0);
    chk("R5", "ready when idle", int'(tx_ready), 1);
  endtask

  initial begin
    nvec     = 0;
    nerr     = 0;
    rst_n    = 1'b0;
    cfg_half = 1'b0;
    cfg_div  = 8'd1;
    tx_wr    = 1'b0;
    tx_data  = 8'h00;
    rx_rd    = 1'b0;
    loop_en  = 1'b0;
    bfs      = 1'b0;
    bsd      = 1'b0;
    repeat (5) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();

    t_period(1'b0, 8'd1, 2, "R1");
    t_period(1'b0, 8'd5, 6, "R1");
    t_period(1'b1, 8'd3, 8, "R1");
    t_period(1'b0, 8'd0, 2, "R1");
    t_period(1'b1, 8'd0, 4, "R1");
    t_period(1'b1, 8'd239, 480, "R2");

    cfg_half = 1'b0;
    cfg_div  = 8'd1;
    t_loop(8'hA5);
    t_loop(8'h01);
    t_loop(8'h80);
    cfg_half = 1'b1;
    cfg_div  = 8'd3;
    t_loop(8'h5A);

    cfg_half = 1'b0;
    cfg_div  = 8'd1;
    t_async(8'h6D, 1'b0, "R6");
    t_async(8'hFF, 1'b1, "R7");
    t_async(8'hB7, 1'b1, "R7");
    t_buffer();
    t_overrun();

    cfg_div = 8'd3;
    t_txhold();

    summary_and_end();
  end

endmodule